// File: doc/BRIEF.md
# Cell Egress Word-to-Byte Converter

This block is the transmit half of a link-layer master on an 8-bit cell bus. User logic keeps cells in a buffer as 27 words of 16 bits. When user logic reports a cell ready and the physical-layer device reports room for a cell, the block fetches the words one at a time. It uses a word address and a one-cycle read-request strobe. It sends each word as two bytes, upper half first, with an active-low transmit enable and a start-of-cell flag on the first byte.

A translate input picks the cell length. When it is high, all 54 bytes of the user cell are sent. When it is low, the lower byte of the third word (byte position 5, counted from zero) is dropped and 53 bytes go out. Because of that drop, the strobe fires on two consecutive cycles at that point, so the byte stream has no gap. If both ready conditions still hold on the last byte, the next cell follows at once. Everything runs on one clock.

Top module: `cell_egress_serializer`

## Requirements
- R1: While idle (tx_en_n high), if cell_ready and phy_cell_avail are both high in a cycle, rd_req is high in that same cycle with word_addr 0. In the next cycle tx_en_n is low, tx_soc is high and tx_byte is bits 15:8 of the word that was on word_in.
- R2: Once a cell has started, all of its bytes are sent and tx_en_n stays low until the last byte, whatever cell_ready and phy_cell_avail do.
- R3: rd_req is a single-cycle strobe. The word on word_in is captured at the clock edge that ends the strobe cycle, and word_addr advances at that same edge. With translate high, two strobes are never adjacent.
- R4: word_addr steps 0x00, 0x01, … 0x1A on successive strobes, returns to 0x00 after the request for word 0x1A, and never exceeds 0x1A.
- R5: With xlate_full high (sampled at the word-0 request), the cell is 54 bytes sent in 54 consecutive cycles. Byte 2k is bits 15:8 and byte 2k+1 is bits 7:0 of word k.
- R6: With xlate_full low (sampled at the word-0 request), byte position 5 (bits 7:0 of word 2) is not sent. The requests for words 2 and 3 fall on consecutive cycles, and the cell is 53 bytes in 53 consecutive cycles.
- R7: tx_soc is high only during the first byte of each cell.
- R8: If cell_ready and phy_cell_avail are both high during the cycle of the last byte, rd_req for word 0 of the next cell is issued in that cycle. The next cell's first byte follows in the next cycle with tx_en_n still low.
- R9: If they are not both high during the last byte, tx_en_n goes high in the next cycle. No request is made while idle unless both are high.
- R10: While rst_n is low (synchronous, active low), tx_en_n is 1, and rd_req, tx_soc, tx_byte and word_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cell_ready | input | 1 | User buffer holds a complete cell |
| phy_cell_avail | input | 1 | Physical-layer device has room for a cell |
| xlate_full | input | 1 | High: send 54 bytes; low: drop byte 5 |
| word_in | input | 16 | Buffer word at word_addr |
| rd_req | output | 1 | One-cycle word fetch strobe |
| word_addr | output | 5 | Word index within the cell |
| tx_en_n | output | 1 | Transmit enable, active low |
| tx_byte | output | 8 | Byte on the cell bus |
| tx_soc | output | 1 | Start-of-cell flag |

## Verification
Two functions can fall in the same cycle: the last byte of one cell goes out while the word-0 request of the next cell is issued. In 53-byte mode, a second pair also shares cycles: the request that skips the dropped byte falls right after the previous request, while that previous word's upper byte is on the bus. The bench holds both ready inputs high across cell ends in each mode, and also drops them at random around the final byte. A model of the byte stream then judges that the next cell's first byte follows with no gap and a single start flag, or that the enable returns high in the next cycle.

// File: rtl/ces_pkg.sv
// Shared sizing constants for the cell egress serializer.
// Assumes a word holds exactly two bytes.
package ces_pkg;
    localparam int unsigned CES_WORD_W     = 16;
    localparam int unsigned CES_BYTE_W     = 8;
    localparam int unsigned CES_CELL_WORDS = 27;
    // Byte position dropped in short-cell mode; must be odd (a lower half).
    localparam int unsigned CES_DROP_POS   = 5;
endpackage

// File: rtl/ces_sequencer.sv
// Cell sequencer: decides when to fetch each word and tracks which byte of
// the cell is on the bus. Issues back-to-back fetches around the dropped
// byte in short-cell mode and chains cells when both ready inputs hold.
// Assumes DROP_POS is odd and smaller than the cell length in bytes.
module ces_sequencer #(
    parameter int unsigned CELL_WORDS = 27,
    parameter int unsigned DROP_POS   = 5,
    localparam int unsigned ADDR_W    = $clog2(CELL_WORDS),
    localparam int unsigned POS_W     = $clog2(2 * CELL_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              full_mode_in,
    output logic              rd_req,
    output logic [ADDR_W-1:0] word_addr,
    output logic              first_word,
    output logic              shift,
    output logic              clear,
    output logic              busy
);
    localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(2 * CELL_WORDS - 1);
    localparam logic [POS_W-1:0]  SKIP_POS  = POS_W'(DROP_POS - 1);
    localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(CELL_WORDS - 1);
    localparam logic [ADDR_W-1:0] SKIP_WORD = ADDR_W'((DROP_POS - 1) / 2);

    logic [POS_W-1:0] pos_q;
    logic             full_q;
    logic             busy_q;
    logic             last_byte;
    logic             req_start;
    logic             req_next;
    logic             req_skip;

    // Request decode: new cell, next word after a lower byte, or skip fetch.
    always_comb begin
        last_byte  = busy_q && (pos_q == LAST_POS);
        req_start  = go && (!busy_q || last_byte);
        req_next   = busy_q && pos_q[0] && (pos_q[POS_W-1:1] < LAST_WORD);
        req_skip   = busy_q && !full_q && (pos_q == SKIP_POS);
        rd_req     = rst_n && (req_start || req_next || req_skip);
        first_word = (word_addr == '0);
        shift      = busy_q && !rd_req && !last_byte;
        clear      = last_byte && !rd_req;
        busy       = busy_q;
    end

    // Position, address and mode state updated on each fetch or byte step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            pos_q     <= '0;
            word_addr <= '0;
            full_q    <= 1'b1;
        end else if (rd_req) begin
            busy_q    <= 1'b1;
            pos_q     <= POS_W'({word_addr, 1'b0});
            word_addr <= (word_addr == LAST_WORD) ? '0 : word_addr + 1'b1;
            if (word_addr == '0) begin
                full_q <= full_mode_in;
            end
        end else if (clear) begin
            busy_q <= 1'b0;
            pos_q  <= '0;
        end else if (shift) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // R3: in full mode a strobe is never followed by another.
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && busy_q && full_q |=> !rd_req);
    // R6: in short mode the fetch of the word holding the dropped byte is
    // followed at once by the next fetch.
    a_r6_skip_chain: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && busy_q && !full_q && (word_addr == SKIP_WORD) |=> rd_req);
    // R2: a started cell is not abandoned before its last byte.
    a_r2_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !last_byte |=> busy_q);
    // R4: address stays within the cell.
    a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        word_addr <= LAST_WORD);
    // R9: no fetch while idle without both ready inputs.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q && !go |-> !rd_req);
endmodule

// File: rtl/ces_byte_path.sv
// Byte datapath: captures a fetched word, drives its upper byte at once,
// holds the lower byte for the following cycle, and flags the first byte.
// Assumes WORD_W is exactly twice BYTE_W.
module ces_byte_path #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned LANES = WORD_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              first_word,
    input  logic              shift,
    input  logic              clear,
    input  logic [WORD_W-1:0] word_in,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_soc
);
    logic [BYTE_W-1:0] lane [LANES];
    logic [BYTE_W-1:0] hold_q;

    // Split the word into byte lanes, lane 0 being the upper half.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_in[(LANES-1-g)*BYTE_W +: BYTE_W];
    end

    // Output byte, held lower byte and start flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= '0;
            hold_q  <= '0;
            tx_soc  <= 1'b0;
        end else if (load) begin
            tx_byte <= lane[0];
            hold_q  <= lane[1];
            tx_soc  <= first_word;
        end else if (shift) begin
            tx_byte <= hold_q;
            tx_soc  <= 1'b0;
        end else if (clear) begin
            tx_byte <= '0;
            tx_soc  <= 1'b0;
        end
    end

    // R7: start flag lasts one byte.
    a_r7_soc_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soc |=> !tx_soc);
endmodule

// File: rtl/cell_egress_serializer.sv
// Top level: ties the sequencer and the byte datapath together and derives
// the active-low transmit enable from the sequencer's busy state.
// Assumes the buffer presents the word at word_addr in the strobe cycle.
module cell_egress_serializer
    import ces_pkg::*;
#(
    parameter int unsigned WORD_W     = CES_WORD_W,
    parameter int unsigned BYTE_W     = CES_BYTE_W,
    parameter int unsigned CELL_WORDS = CES_CELL_WORDS,
    parameter int unsigned DROP_POS   = CES_DROP_POS,
    localparam int unsigned ADDR_W    = $clog2(CELL_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_ready,
    input  logic              phy_cell_avail,
    input  logic              xlate_full,
    input  logic [WORD_W-1:0] word_in,
    output logic              rd_req,
    output logic [ADDR_W-1:0] word_addr,
    output logic              tx_en_n,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_soc
);
    logic go;
    logic first_word;
    logic shift;
    logic clear;
    logic busy;

    // Both ready conditions together allow a cell to start.
    assign go      = cell_ready && phy_cell_avail;
    assign tx_en_n = !busy;

    ces_sequencer #(
        .CELL_WORDS (CELL_WORDS),
        .DROP_POS   (DROP_POS)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .full_mode_in (xlate_full),
        .rd_req       (rd_req),
        .word_addr    (word_addr),
        .first_word   (first_word),
        .shift        (shift),
        .clear        (clear),
        .busy         (busy)
    );

    ces_byte_path #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) path_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (rd_req),
        .first_word (first_word),
        .shift      (shift),
        .clear      (clear),
        .word_in    (word_in),
        .tx_byte    (tx_byte),
        .tx_soc     (tx_soc)
    );

    // R7: the start flag only appears with the enable asserted.
    a_r7_soc_in_cell: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soc |-> !tx_en_n);
    // R1: a fetch while idle starts a cell on the next cycle.
    a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_n && rd_req |=> !tx_en_n && tx_soc);
endmodule

// File: tb/cell_egress_serializer_tb.sv
module cell_egress_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cell_ready;
    logic        phy_cell_avail;
    logic        xlate_full;
    logic [15:0] word_in;
    logic        rd_req;
    logic [4:0]  word_addr;
    logic        tx_en_n;
    logic [7:0]  tx_byte;
    logic        tx_soc;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    bit mon_on = 0;

    always #5 clk = ~clk;

    cell_egress_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .cell_ready(cell_ready),
        .phy_cell_avail(phy_cell_avail), .xlate_full(xlate_full),
        .word_in(word_in), .rd_req(rd_req), .word_addr(word_addr),
        .tx_en_n(tx_en_n), .tx_byte(tx_byte), .tx_soc(tx_soc)
    );

    function automatic logic [15:0] word_of(int a);
        return {8'(a * 37 + 90), 8'(a * 53 + 17)};
    endfunction

    function automatic logic [7:0] exp_byte(int pos);
        logic [15:0] w;
        w = word_of(pos / 2);
        return (pos % 2 == 1) ? w[7:0] : w[15:8];
    endfunction

    assign word_in = word_of(int'(word_addr));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Stream model state
    int pos = 0;
    bit cur_full = 1;
    bit next_full = 1;
    int exp_addr = 0;
    bit prev_req = 0;
    bit pend_last = 0;
    bit go_last = 0;
    int cells_done = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            automatic bit go = cell_ready && phy_cell_avail;
            if (pend_last) begin
                pend_last = 0;
                if (go_last) chk(!tx_en_n && tx_soc, "R8 next cell follows", {tx_en_n, tx_soc}, 2'b01);
                else chk(tx_en_n, "R9 enable released", tx_en_n, 1);
            end
            if (!tx_en_n) begin
                if (pos == 0) cur_full = next_full;
                chk(tx_byte == exp_byte(pos), cur_full ? "R5 byte" : "R6 byte",
                    tx_byte, exp_byte(pos));
                chk(tx_soc == (pos == 0), "R7 soc", tx_soc, pos == 0);
                if (pos == 53) begin
                    pend_last = 1; go_last = go; pos = 0; cells_done++;
                end else if (!cur_full && pos == 4) pos = 6;
                else pos = pos + 1;
            end else begin
                chk(pos == 0, "R2 enable held until cell ends", pos, 0);
                if (go) chk(rd_req && word_addr == 0, "R1 start request", {rd_req, word_addr}, 6'h20);
                else chk(!rd_req, "R9 no idle request", rd_req, 0);
            end
            if (rd_req) begin
                chk(int'(word_addr) == exp_addr, "R4 address", word_addr, exp_addr);
                if (prev_req)
                    chk(!next_full && exp_addr == 3, "R3 strobe adjacency", exp_addr, 3);
                if (exp_addr == 0) next_full = xlate_full;
                exp_addr = (exp_addr + 1) % 27;
            end
            prev_req = rd_req;
        end
    end

    task automatic drive(input bit r, input bit a, input bit x);
        @(posedge clk); #1;
        cell_ready = r; phy_cell_avail = a; xlate_full = x;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int c0;
        void'($urandom(32'd2718));
        rst_n = 0; cell_ready = 1; phy_cell_avail = 1; xlate_full = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tx_en_n == 1, "R10 reset enable", tx_en_n, 1);
        chk(rd_req == 0, "R10 reset strobe", rd_req, 0);
        chk(word_addr == 0, "R10 reset address", word_addr, 0);
        chk(tx_soc == 0 && tx_byte == 0, "R10 reset byte", {tx_soc, tx_byte}, 0);
        cell_ready = 0;
        @(posedge clk); #1; rst_n = 1;
        mon_on = 1;
        // R2: full cell, ready inputs dropped mid-cell
        drive(1, 1, 1);
        repeat (8) drive(0, 0, 0);
        repeat (70) drive(0, 0, 1);
        chk(cells_done == 1, "R2 cell completed", cells_done, 1);
        // R6, R8: chained short cells
        c0 = cells_done;
        drive(1, 1, 0);
        repeat (170) drive(1, 1, 0);
        repeat (70) drive(0, 1, 0);
        chk(cells_done - c0 >= 3, "R8 chained cells", cells_done - c0, 3);
        // R5, R8: chained full cells
        c0 = cells_done;
        repeat (170) drive(1, 1, 1);
        repeat (70) drive(1, 0, 1);
        chk(cells_done - c0 >= 3, "R5 chained cells", cells_done - c0, 3);
        // Random mix
        for (int i = 0; i < 20000; i++)
            drive($urandom % 4 != 0, $urandom % 3 != 0, $urandom % 2);
        repeat (80) drive(0, 0, 1);
        chk(tx_en_n == 1 && pos == 0, "R9 idle at end", tx_en_n, 1);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule